// File: doc/BRIEF.md
# Parallel NOR Flash Configuration Reader

This block is a read-only master that pulls a configuration image out of an external parallel NOR flash. It uses only plain asynchronous reads. The block puts an address on the flash address bus and enables the device. It waits a set number of clock cycles for the access time to pass. It then captures the data bus on a rising clock edge and passes the word downstream on a valid/ready stream. The address then moves one step and the cycle repeats. A three-bit mode input decides whether the sweep runs up from address zero or down from the top of the address space. Any other mode code keeps the block idle.

The sweep ends when the `done` input is seen high. After that the flash enables are released. If the last address of the sweep has been delivered and `done` is still low, the block sets a sticky error flag and gives a one-cycle fallback request. It then returns to idle, and from idle it starts a new sweep if a valid mode is still applied. Each byte is delivered with its bit order reversed. The data bus can be used 16 bits wide or 8 bits wide.

The downstream stream obeys these back-pressure rules. `out_valid` rises only once a word has been captured. While `out_valid` is high and `out_ready` is low, `out_data` and `flash_addr` hold still. The address moves on only after a handshake, which is `out_valid` and `out_ready` high at the same rising edge. The block never drops a word that has been offered.

Top module: `nor_boot_streamer`

## Requirements
- R1: After reset, `flash_ce_n`, `flash_oe_n` and `flash_we_n` are high, and `out_valid`, `err_flag` and `fallback_req` are low.
- R2: A sweep starts only when `mode_sel` is 3'b010 (ascending) or 3'b011 (descending) and `done` is low. Any other code leaves the block idle, with `flash_ce_n` and `flash_oe_n` high and no word offered.
- R3: In ascending mode the first address is 0, and each following read is at the previous address plus one.
- R4: In descending mode the first address is all ones (26'h3FFFFFF with the default `ADDR_W` of 26), and each following read is at the previous address minus one.
- R5: For each read, the address is driven and `flash_ce_n` and `flash_oe_n` are low for `WAIT_CYC`+1 cycles before the data bus is sampled. `out_valid` therefore rises `WAIT_CYC`+1 cycles after the handshake of the previous word.
- R6: When `bus16` is 1 at the start of a sweep, each byte lane of `flash_dq` is delivered bit-reversed in its own lane. Bus bit 0 goes to `out_data` bit 7, and bus bit 8 goes to `out_data` bit 15.
- R7: When `bus16` is 0 at the start of a sweep, only `flash_dq[7:0]` is used. It is delivered bit-reversed in `out_data[7:0]`, and `out_data[15:8]` is zero.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `flash_addr` do not change.
- R9: If `done` is high during the access wait, or at the handshake of a word, the block stops reading. `flash_ce_n` and `flash_oe_n` go high, and no further word is offered while `done` stays high.
- R10: If the handshake of the last address of a sweep (all ones ascending, zero descending) happens with `done` low, `err_flag` is set and stays set until reset. `fallback_req` is high for exactly one cycle, and the block then restarts from idle.
- R11: `flash_we_n` is held high at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock; flash data is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Sweep mode: 3'b010 ascending, 3'b011 descending, other codes idle |
| bus16 | input | 1 | Data bus width, latched at sweep start: 1 = 16 bits, 0 = 8 bits |
| done | input | 1 | Configuration-complete indication that ends the sweep |
| flash_addr | output | ADDR_W | Flash address bus |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| flash_oe_n | output | 1 | Flash output enable, active low |
| flash_we_n | output | 1 | Flash write enable, held inactive high |
| flash_dq | input | DATA_W | Flash read data bus |
| out_valid | output | 1 | Stream valid |
| out_ready | input | 1 | Stream ready from the consumer |
| out_data | output | DATA_W | Bit-reversed image word |
| err_flag | output | 1 | Sticky flag: end of address space reached without done |
| fallback_req | output | 1 | One-cycle request to restart from a fallback image |

## Verification
The sweep is tested in both directions and at both bus widths. The flash model returns a different word for every address, so a wrong address step or a wrong byte-lane reversal shows up on the very first words. The consumer's ready line is toggled at random, which tests that words are held under back-pressure. Ready is also held high in some stretches, which lets the access-wait gap be measured exactly. The bench uses a reduced address width, so full sweeps in each direction reach the terminal address. These sweeps separate a correct error and fallback pulse from an off-by-one end test. `done` is raised both while a word is pending and in the middle of an access wait, to tell the two stop paths apart.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SHOW,
    ST_STOP,
    ST_FAIL
  } nbs_state_e;

  localparam logic [2:0] MODE_ASC  = 3'b010;
  localparam logic [2:0] MODE_DESC = 3'b011;

endpackage

// File: rtl/nbs_addr_ctr.sv
module nbs_addr_ctr #(
  parameter int ADDR_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_up,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              at_end
);

  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

  logic up_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      up_q <= 1'b1;
    end else if (load) begin
      addr <= load_up ? '0 : TOP_ADDR;
      up_q <= load_up;
    end else if (step) begin
      addr <= up_q ? addr + 1'b1 : addr - 1'b1;
    end
  end

  assign at_end = up_q ? (addr == TOP_ADDR) : (addr == '0);

endmodule

// File: rtl/nbs_wait_timer.sv
module nbs_wait_timer #(
  parameter int WAIT_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);

  localparam int CW = (WAIT_CYC < 1) ? 1 : $clog2(WAIT_CYC + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(WAIT_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= LOAD_VAL;
    end else if (run && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/nbs_lane_reverse.sv
module nbs_lane_reverse #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] din,
  input  logic              wide,
  output logic [DATA_W-1:0] dout
);

  localparam int NB = DATA_W / 8;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    for (genvar b = 0; b < 8; b++) begin : g_bit
      if (g == 0) begin : g_base
        assign dout[g*8 + 7 - b] = din[g*8 + b];
      end else begin : g_upper
        assign dout[g*8 + 7 - b] = din[g*8 + b] & wide;
      end
    end
  end

endmodule

// File: rtl/nor_boot_streamer.sv
module nor_boot_streamer
  import nbs_pkg::*;
#(
  parameter int ADDR_W   = 26,
  parameter int DATA_W   = 16,
  parameter int WAIT_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_sel,
  input  logic              bus16,
  input  logic              done,
  output logic [ADDR_W-1:0] flash_addr,
  output logic              flash_ce_n,
  output logic              flash_oe_n,
  output logic              flash_we_n,
  input  logic [DATA_W-1:0] flash_dq,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              err_flag,
  output logic              fallback_req
);

  nbs_state_e state_q, state_d;

  logic              mode_ok;
  logic              mode_up;
  logic              ld_addr;
  logic              step_addr;
  logic              at_end;
  logic              ld_timer;
  logic              run_timer;
  logic              expired;
  logic              capture;
  logic              set_err;
  logic              wide_q;
  logic              err_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] rev_data;

  assign mode_ok = (mode_sel == MODE_ASC) || (mode_sel == MODE_DESC);
  assign mode_up = (mode_sel == MODE_ASC);

  nbs_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ld_addr),
    .load_up (mode_up),
    .step    (step_addr),
    .addr    (flash_addr),
    .at_end  (at_end)
  );

  nbs_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ld_timer),
    .run     (run_timer),
    .expired (expired)
  );

  nbs_lane_reverse #(.DATA_W(DATA_W)) u_rev (
    .din  (flash_dq),
    .wide (wide_q),
    .dout (rev_data)
  );

  always_comb begin
    state_d   = state_q;
    ld_addr   = 1'b0;
    step_addr = 1'b0;
    ld_timer  = 1'b0;
    run_timer = 1'b0;
    capture   = 1'b0;
    set_err   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (mode_ok && !done) begin
          ld_addr  = 1'b1;
          ld_timer = 1'b1;
          state_d  = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (done) begin
          state_d = ST_STOP;
        end else if (expired) begin
          capture = 1'b1;
          state_d = ST_SHOW;
        end else begin
          run_timer = 1'b1;
        end
      end
      ST_SHOW: begin
        if (out_ready) begin
          if (done) begin
            state_d = ST_STOP;
          end else if (at_end) begin
            set_err = 1'b1;
            state_d = ST_FAIL;
          end else begin
            step_addr = 1'b1;
            ld_timer  = 1'b1;
            state_d   = ST_WAIT;
          end
        end
      end
      ST_STOP: begin
        if (!done) state_d = ST_IDLE;
      end
      ST_FAIL: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
      wide_q  <= 1'b1;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (set_err) err_q <= 1'b1;
      if (ld_addr) wide_q <= bus16;
      if (capture) data_q <= rev_data;
    end
  end

  assign flash_ce_n   = !((state_q == ST_WAIT) || (state_q == ST_SHOW));
  assign flash_oe_n   = flash_ce_n;
  assign flash_we_n   = 1'b1;
  assign out_valid    = (state_q == ST_SHOW);
  assign out_data     = data_q;
  assign err_flag     = err_q;
  assign fallback_req = (state_q == ST_FAIL);

endmodule

// File: rtl/nbs_checker.sv
module nbs_checker #(
  parameter int ADDR_W = 26,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic [ADDR_W-1:0] flash_addr,
  input logic              flash_ce_n,
  input logic              flash_oe_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              err_flag,
  input logic              fallback_req
);

  a_r8_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(flash_addr));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fallback_req |=> !fallback_req);

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  a_r10_err_with_request: assert property (@(posedge clk) disable iff (!rst_n)
    fallback_req |-> err_flag);

  a_r5_valid_while_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !flash_ce_n && !flash_oe_n);

  a_r5_addr_still_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
    !flash_oe_n && !out_valid && $past(!flash_oe_n) && $past(!out_valid) |-> $stable(flash_addr));

  // R3 and R4: one step per accepted word, in either direction
  a_r3_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(out_valid && out_ready && !done) && !flash_ce_n
      |-> (flash_addr == $past(flash_addr) + 1'b1) || (flash_addr == $past(flash_addr) - 1'b1));

  a_r9_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done && $past(done) && $past(flash_ce_n) |-> flash_ce_n && !out_valid);

endmodule

bind nor_boot_streamer nbs_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .done         (done),
  .flash_addr   (flash_addr),
  .flash_ce_n   (flash_ce_n),
  .flash_oe_n   (flash_oe_n),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_data     (out_data),
  .err_flag     (err_flag),
  .fallback_req (fallback_req)
);

// File: tb/sim_nor_boot_streamer.sv
module sim_nor_boot_streamer;

  localparam int AW = 6;
  localparam int DW = 16;
  localparam int WC = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, done, bus16, out_ready;
  logic [2:0]    mode_sel;
  logic [AW-1:0] flash_addr;
  logic          flash_ce_n, flash_oe_n, flash_we_n;
  logic [DW-1:0] flash_dq, out_data;
  logic          out_valid, err_flag, fallback_req;

  int checks = 0;
  int errors = 0;
  bit reported = 0;

  nor_boot_streamer #(.ADDR_W(AW), .DATA_W(DW), .WAIT_CYC(WC)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .bus16(bus16), .done(done),
    .flash_addr(flash_addr), .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n),
    .flash_we_n(flash_we_n), .flash_dq(flash_dq), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .err_flag(err_flag),
    .fallback_req(fallback_req)
  );

  function automatic logic [15:0] flash_word(logic [AW-1:0] a);
    return 16'h5A3 + 16'(a) * 16'd2371;
  endfunction

  function automatic logic [15:0] expect_word(logic [AW-1:0] a, logic w);
    logic [15:0] raw = flash_word(a);
    logic [15:0] r = '0;
    for (int i = 0; i < 8; i++) begin
      r[7 - i] = raw[i];
      if (w) r[15 - i] = raw[8 + i];
    end
    return r;
  endfunction

  assign flash_dq = flash_word(flash_addr);

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // stream monitor
  int hs = 0;
  int fb_pulses = 0;
  int gap = 0;
  bit armed = 0;
  bit up_dir = 1;
  bit prev_fb = 0;
  bit prev_valid = 0;
  bit hold_pending = 0;
  logic [AW-1:0] exp_addr = '0;
  logic [DW-1:0] held_data;
  logic [AW-1:0] held_addr;

  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pending)
        check(out_valid && out_data == held_data && flash_addr == held_addr,
              "R8", "held word", {16'(flash_addr), out_data}, {16'(held_addr), held_data});
      if (out_valid && !prev_valid && armed)
        check(gap == WC + 1, "R5", "wait gap", gap, WC + 1);
      if (!out_valid) gap++;
      if (out_valid && out_ready) begin
        check(flash_addr == exp_addr, up_dir ? "R3" : "R4", "address", flash_addr, exp_addr);
        check(out_data == expect_word(flash_addr, bus16), bus16 ? "R6" : "R7", "data",
              out_data, expect_word(flash_addr, bus16));
        exp_addr = up_dir ? flash_addr + 1'b1 : flash_addr - 1'b1;
        hs++;
        gap = 0;
        armed = 1;
      end
      if (out_valid && !out_ready) begin
        hold_pending = 1;
        held_data = out_data;
        held_addr = flash_addr;
      end else begin
        hold_pending = 0;
      end
      if (flash_ce_n) armed = 0;
      if (fallback_req) begin
        fb_pulses++;
        check(!prev_fb && err_flag, "R10", "pulse width / err", {prev_fb, err_flag}, 2'b01);
        exp_addr = up_dir ? '0 : '1;
      end
      prev_fb = fallback_req;
      prev_valid = out_valid;
    end
  end

  task automatic tick(int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic run_words(int n, bit rnd);
    int start = hs;
    while (hs - start < n) begin
      @(posedge clk);
      #1;
      out_ready = rnd ? (($urandom % 3) != 0) : 1'b1;
    end
    out_ready = 1'b1;
  endtask

  task automatic stop_sweep();
    done = 1'b1;
    tick(3);
    mode_sel = 3'b000;
    tick(2);
    done = 1'b0;
    tick(3);
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int hs_mark;
    int fb_mark;
    void'($urandom(32'h1C0FFEE));
    rst_n = 1'b0; done = 1'b0; bus16 = 1'b1; out_ready = 1'b0; mode_sel = 3'b000;
    tick(4);
    // R1 reset state
    check(flash_ce_n && flash_oe_n && flash_we_n, "R1", "enables", {flash_ce_n, flash_oe_n, flash_we_n}, 3'b111);
    check(!out_valid && !err_flag && !fallback_req, "R1", "valid/err/fb",
          {out_valid, err_flag, fallback_req}, 3'b000);
    rst_n = 1'b1;

    // R2 unused mode codes keep idle
    tick(20);
    check(flash_ce_n && flash_oe_n && hs == 0, "R2", "mode 000 idle", {flash_ce_n, flash_oe_n}, 2'b11);
    mode_sel = 3'b111;
    tick(20);
    check(flash_ce_n && flash_oe_n && hs == 0, "R2", "mode 111 idle", {flash_ce_n, flash_oe_n}, 2'b11);
    mode_sel = 3'b001;
    tick(20);
    check(flash_ce_n && hs == 0, "R2", "mode 001 idle", hs, 0);

    // R3/R6 ascending, 16-bit, random back-pressure, then R5 directed
    up_dir = 1; exp_addr = '0; bus16 = 1'b1; mode_sel = 3'b010;
    run_words(25, 1);
    run_words(6, 0);
    // R9 stop at a pending word
    done = 1'b1;
    tick(6);
    hs_mark = hs;
    tick(10);
    check(flash_ce_n && flash_oe_n && !out_valid && hs == hs_mark, "R9", "quiet after done",
          {flash_ce_n, flash_oe_n, out_valid}, 3'b110);
    mode_sel = 3'b000;
    tick(2);
    done = 1'b0;
    tick(3);
    check(flash_ce_n && hs == hs_mark, "R2", "idle after done drop", hs, hs_mark);

    // R4/R7 descending, 8-bit
    up_dir = 0; exp_addr = '1; bus16 = 1'b0; mode_sel = 3'b011;
    run_words(20, 1);
    stop_sweep();

    // R9 done during access wait: no word delivered
    up_dir = 1; exp_addr = '0; bus16 = 1'b1; out_ready = 1'b1;
    hs_mark = hs;
    mode_sel = 3'b010;
    tick(2);
    done = 1'b1;
    tick(8);
    check(hs == hs_mark && flash_ce_n, "R9", "done in wait", hs, hs_mark);
    mode_sel = 3'b000;
    tick(1);
    done = 1'b0;
    tick(3);

    // R10 ascending sweep runs off the top
    check(!err_flag, "R10", "err clear before terminal", err_flag, 0);
    fb_mark = fb_pulses;
    up_dir = 1; exp_addr = '0; mode_sel = 3'b010;
    run_words(1 << AW, 1);
    tick(2);
    check(err_flag && fb_pulses == fb_mark + 1, "R10", "ascending terminal", fb_pulses, fb_mark + 1);
    run_words(3, 1);
    check(err_flag, "R10", "err sticky", err_flag, 1);
    stop_sweep();

    // R10 descending sweep runs off the bottom
    up_dir = 0; exp_addr = '1; bus16 = 1'b0; mode_sel = 3'b011;
    run_words(1 << AW, 0);
    tick(2);
    check(err_flag && fb_pulses == fb_mark + 2, "R10", "descending terminal", fb_pulses, fb_mark + 2);
    run_words(2, 1);
    stop_sweep();

    check(flash_we_n, "R11", "write enable high", flash_we_n, 1);
    check(hs > 150, "R3", "words delivered", hs, 150);
    report();
  end

endmodule